// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Access Controller

This block lets synchronous logic use an external asynchronous static RAM of 512K words of 16 bits. The user side presents a one-cycle request strobe, a read/write flag, a word address, write data and a two-bit byte mask. The controller runs the strobe sequence on the memory pins and returns a one-cycle ready pulse. For reads, the ready pulse comes with the read data.

The memory is selected only while its active-low chip enable is low and its active-high chip enable is high. The controller drives both pins together, so the memory is selected during an access and deselected at all other times. Each access holds its strobes for a wait count derived from the clock period, so a 45 ns memory cycle is always met. The shared data bus follows a fixed discipline. The controller drives the bus only during writes. The bus is left floating for one cycle before output enable goes low. Write enable is released one cycle before the chip is deselected.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After reset and whenever no access is running, the memory is deselected (`mem_ce_n`=1, `mem_ce2`=0), `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_drive`=0 and `rdy`=0.
- R2: A write with a non-zero mask selects the memory and holds `mem_we_n` low for exactly WAIT_CYC cycles. During that time the bus is driven with the write data. Mask bit 0 enables the low lane (bits 7:0, `mem_lb_n` low), and mask bit 1 enables the high lane (bits 15:8, `mem_ub_n` low).
- R3: While the memory is selected, the address, the byte enables and the driven data do not change. `mem_we_n` rises one cycle before the memory is deselected.
- R4: A read first spends one selected cycle with the bus released and `mem_oe_n` high. It then holds `mem_oe_n` low and `mem_we_n` high for exactly WAIT_CYC cycles.
- R5: Read data returns the memory value in the lanes the mask enables and zero in the other lanes. It is valid while `rdy` is high and is held until the next read completes.
- R6: The controller never drives the data bus while `mem_oe_n` is low.
- R7: A request with mask 00 never selects the memory. Its `rdy` pulse appears in the first cycle after the accepting edge.
- R8: `rdy` is a single-cycle pulse. For reads and writes with a non-zero mask, it appears in the WAIT_CYC+2-th cycle after the accepting edge.
- R9: A request raised while an access is in progress is ignored. It gives no ready pulse and does not touch the memory.
- R10: WAIT_CYC equals ceil(TCYC_PS / CLK_PS). This is 9 for a 5 ns clock and a 45 ns cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request strobe, accepted only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lane mask, bit 0 low lane, bit 1 high lane |
| rdy | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read data, masked per lane |
| mem_addr | output | 19 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low enable for bits 15:8 |
| mem_lb_n | output | 1 | Active-low enable for bits 7:0 |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_drive | output | 1 | Output enable of the data bus pad driver |
| mem_dq_in | input | 16 | Data received from the memory bus |

## Verification
The hardest situation to reach is a request that arrives in the middle of a running access. The bench starts a write and, a few cycles into the strobe window, raises a second request to a different address. It then counts ready pulses and reads the second address back to show that nothing was written there. The bench's memory model returns a fixed junk pattern on any lane that is not properly enabled or read out of turn. An early capture, a wrong lane mask or a missing turnaround cycle therefore shows up as wrong data. Every mask is swept across several addresses for both directions.

// File: rtl/sram_ctrl_pkg.sv
// Shared types and helpers for the byte-lane SRAM controller.
// Assumes: integer picosecond timing parameters.
package sram_ctrl_pkg;

    // Access sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_ACT,
        ST_W_HOLD,
        ST_R_GAP,
        ST_R_ACT,
        ST_DONE
    } seq_state_t;

    // Ceiling division used to size the strobe window.
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
// Down-counter that times the strobe window of one access.
// A load sets it to WAIT_CYC-1. Each tick then counts down toward zero,
// and done is high at zero, so a window spans WAIT_CYC cycles.
// Assumes: WAIT_CYC >= 1.
module sram_wait_timer #(
    parameter int WAIT_CYC = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
    localparam logic [CNT_W-1:0] START = CNT_W'(WAIT_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    // Load the window length, or count down while the window runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= START;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // The counter never leaves its programmed range (R10).
    p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= START);
endmodule

// File: rtl/sram_lane_mux.sv
// Per-lane byte enables and read-data masking.
// A lane whose mask bit is set gets its active-low enable while the chip is
// selected. Read data of lanes that are not enabled is forced to zero.
// Assumes: lane 0 is the low-order lane.
module sram_lane_mux #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES-1:0]        mask,
    input  logic                    active,
    input  logic [LANES*LANE_W-1:0] rd_raw,
    output logic [LANES-1:0]        be_n,
    output logic [LANES*LANE_W-1:0] rd_masked
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        // Enable one lane while the access is active and its mask bit is set.
        assign be_n[l] = !(active && mask[l]);
        // Pass this lane's read byte, or zero when the lane is not selected.
        assign rd_masked[l*LANE_W +: LANE_W] = mask[l] ? rd_raw[l*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_seq_fsm.sv
// Access sequencer. It walks a request through the strobe phases and
// decodes the pin-level controls from its registered state.
// Write: active window, then one hold cycle with write enable high.
// Read: one turnaround cycle, then the output-enable window.
// Mask 00 goes straight to completion.
// Assumes: the wait timer is loaded when a window starts.
module sram_seq_fsm
    import sram_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       req_wr,
    input  logic       mask_zero,
    input  logic       timer_done,
    output seq_state_t state,
    output logic       accept,
    output logic       timer_load,
    output logic       timer_tick,
    output logic       capture,
    output logic       sel,
    output logic       we_act,
    output logic       oe_act,
    output logic       dq_drive,
    output logic       rdy
);
    seq_state_t state_q, state_d;

    // Next-state and timer control.
    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    if (mask_zero) begin
                        state_d = ST_DONE;
                    end else if (req_wr) begin
                        state_d    = ST_W_ACT;
                        timer_load = 1'b1;
                    end else begin
                        state_d = ST_R_GAP;
                    end
                end
            end
            ST_W_ACT:  if (timer_done) state_d = ST_W_HOLD;
            ST_W_HOLD: state_d = ST_DONE;
            ST_R_GAP: begin
                state_d    = ST_R_ACT;
                timer_load = 1'b1;
            end
            ST_R_ACT:  if (timer_done) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Pin-level controls decoded from the current state.
    always_comb begin
        sel      = (state_q == ST_W_ACT) || (state_q == ST_W_HOLD) ||
                   (state_q == ST_R_GAP) || (state_q == ST_R_ACT);
        we_act   = (state_q == ST_W_ACT);
        oe_act   = (state_q == ST_R_ACT);
        dq_drive = (state_q == ST_W_ACT) || (state_q == ST_W_HOLD);
        rdy      = (state_q == ST_DONE);
    end

    assign state      = state_q;
    assign accept     = (state_q == ST_IDLE) && req;
    assign timer_tick = (state_q == ST_W_ACT) || (state_q == ST_R_ACT);
    assign capture    = (state_q == ST_R_ACT) && timer_done;

    // Ready lasts exactly one cycle (R8).
    p_ready_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);
    // An empty mask skips every strobe phase (R7).
    p_mask_zero_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req && mask_zero) |=> (state_q == ST_DONE));
    // A request seen while busy does not restart the sequence (R9).
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_W_ACT && !timer_done) |=> (state_q == ST_W_ACT));
endmodule

// File: rtl/sram_byte_ctrl.sv
// Top of the byte-lane asynchronous SRAM controller.
// It latches a request when idle, runs the sequencer and wait timer,
// and drives the memory pins and the split data bus (out, drive, in).
// Assumes: CLK_PS is the clock period and TCYC_PS the memory cycle, both in ps.
module sram_byte_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W  = 19,
    parameter int LANES   = 2,
    parameter int LANE_W  = 8,
    parameter int CLK_PS  = 5000,
    parameter int TCYC_PS = 45000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req,
    input  logic                    req_wr,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LANES*LANE_W-1:0] req_wdata,
    input  logic [LANES-1:0]        req_mask,
    output logic                    rdy,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic                    mem_ce_n,
    output logic                    mem_ce2,
    output logic                    mem_we_n,
    output logic                    mem_oe_n,
    output logic                    mem_ub_n,
    output logic                    mem_lb_n,
    output logic [LANES*LANE_W-1:0] mem_dq_out,
    output logic                    mem_dq_drive,
    input  logic [LANES*LANE_W-1:0] mem_dq_in
);
    localparam int DATA_W   = LANES * LANE_W;
    localparam int WAIT_CYC = int'(ceil_div(CLK_PS > 0 ? TCYC_PS : 1, CLK_PS > 0 ? CLK_PS : 1));

    seq_state_t          state;
    logic                accept, t_load, t_tick, t_done, capture;
    logic                sel, we_act, oe_act, dq_drive;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q, rdata_q, rd_masked;
    logic [LANES-1:0]    mask_q, be_n;
    logic                wr_q;

    // Request capture: address, direction, data and mask are held for the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
            wr_q    <= req_wr;
        end
    end

    // Read data register, loaded at the last cycle of the output-enable window.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= rd_masked;
    end

    sram_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_wr     (req_wr),
        .mask_zero  (req_mask == '0),
        .timer_done (t_done),
        .state      (state),
        .accept     (accept),
        .timer_load (t_load),
        .timer_tick (t_tick),
        .capture    (capture),
        .sel        (sel),
        .we_act     (we_act),
        .oe_act     (oe_act),
        .dq_drive   (dq_drive),
        .rdy        (rdy)
    );

    sram_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .tick  (t_tick),
        .done  (t_done)
    );

    sram_lane_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .mask      (mask_q),
        .active    (sel),
        .rd_raw    (mem_dq_in),
        .be_n      (be_n),
        .rd_masked (rd_masked)
    );

    assign rd_data      = rdata_q;
    assign mem_addr     = addr_q;
    assign mem_ce_n     = !sel;
    assign mem_ce2      = sel;
    assign mem_we_n     = !we_act;
    assign mem_oe_n     = !oe_act;
    assign mem_lb_n     = be_n[0];
    assign mem_ub_n     = be_n[LANES-1];
    assign mem_dq_out   = wdata_q;
    assign mem_dq_drive = dq_drive && wr_q;

    // Idle pins leave the memory deselected and quiet (R1).
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_we_n && mem_oe_n && !mem_dq_drive && !mem_ce2));
    // Address and lane enables stay put while the chip is selected (R3).
    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_ub_n) && $stable(mem_lb_n)));
    // Write enable is released while the chip is still selected (R3).
    p_we_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> !mem_ce_n);
    // A floating, selected cycle precedes output enable (R4).
    p_turnaround_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> $past(!mem_dq_drive && !mem_ce_n));
    // The bus is never driven while the memory may drive it (R6).
    p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_drive && !mem_oe_n));
endmodule

// File: tb/sram_byte_ctrl_tb.sv
// Bench: a behavioural memory model plus a pin monitor, and sweeps of masks and addresses.
module sram_byte_ctrl_tb;
    localparam int WAIT = (45000 + 5000 - 1) / 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_wr = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rdy;
    logic [15:0] rd_data, mem_dq_out, mem_dq_in;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_drive;

    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    sram_byte_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_mask(req_mask), .rdy(rdy), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    // Memory model and scoreboard, indexed by the low 8 address bits.
    logic [15:0] bmem [256];
    logic [15:0] smem [256];

    wire sel_w = !mem_ce_n && mem_ce2;
    wire rd_w  = sel_w && !mem_oe_n && mem_we_n;
    always_comb begin
        mem_dq_in[7:0]  = (rd_w && !mem_lb_n) ? bmem[mem_addr[7:0]][7:0]  : 8'hA5;
        mem_dq_in[15:8] = (rd_w && !mem_ub_n) ? bmem[mem_addr[7:0]][15:8] : 8'hA5;
    end

    // Monitor state.
    logic [18:0] exp_addr;
    logic [15:0] exp_data;
    logic [1:0]  exp_mask;
    int we_cnt, oe_cnt, sel_cnt, rdy_cnt;
    int v_stab = 0, v_we = 0, v_gap = 0, v_cont = 0, v_idle = 0, v_drv = 0;
    logic p_we_n = 1'b1, p_oe_n = 1'b1, p_sel = 1'b0, p_drive = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sel_w) begin
                sel_cnt++;
                if (mem_addr != exp_addr || mem_lb_n != !exp_mask[0] || mem_ub_n != !exp_mask[1]) v_stab++;
                if (mem_dq_drive && mem_dq_out != exp_data) v_stab++;
            end else if (!mem_we_n || !mem_oe_n || mem_dq_drive || mem_ce2) v_idle++;
            if (sel_w && !mem_we_n) begin
                we_cnt++;
                if (!mem_dq_drive) v_drv++;
                if (!mem_lb_n) bmem[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
                if (!mem_ub_n) bmem[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
            end
            if (rd_w) oe_cnt++;
            if (!p_we_n && mem_we_n && !sel_w) v_we++;
            if (!mem_oe_n && p_oe_n && !(p_sel && !p_drive && p_oe_n)) v_gap++;
            if (mem_dq_drive && !mem_oe_n) v_cont++;
            if (rdy) rdy_cnt++;
        end
        p_we_n <= mem_we_n; p_oe_n <= mem_oe_n; p_sel <= sel_w; p_drive <= mem_dq_drive;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One access: accept, wait for ready, then check latency, strobe counts and data.
    task automatic do_op(input bit wr, input logic [18:0] a, input logic [15:0] d, input logic [1:0] m);
        int lat;
        logic [15:0] expr;
        @(negedge clk);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
        exp_addr = a; exp_data = d; exp_mask = m;
        @(posedge clk);
        we_cnt = 0; oe_cnt = 0; sel_cnt = 0; rdy_cnt = 0;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!rdy && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        if (m == 2'b00) begin
            chk(lat == 1, "R7 latency", lat, 1);
            chk(sel_cnt == 0, "R7 no select", sel_cnt, 0);
        end else begin
            chk(lat == WAIT + 2, "R8 latency", lat, WAIT + 2);
            if (wr) begin
                chk(we_cnt == WAIT, "R2 R10 we window", we_cnt, WAIT);
                chk(sel_cnt == WAIT + 1, "R3 select span", sel_cnt, WAIT + 1);
            end else begin
                chk(oe_cnt == WAIT, "R4 R10 oe window", oe_cnt, WAIT);
                chk(sel_cnt == WAIT + 1, "R4 gap span", sel_cnt, WAIT + 1);
            end
        end
        if (!wr && m != 2'b00) begin
            expr = {m[1] ? smem[a[7:0]][15:8] : 8'h00, m[0] ? smem[a[7:0]][7:0] : 8'h00};
            chk(rd_data == expr, "R5 read data", rd_data, expr);
        end
        if (wr) begin
            if (m[0]) smem[a[7:0]][7:0]  = d[7:0];
            if (m[1]) smem[a[7:0]][15:8] = d[15:8];
        end
        expr = rd_data;
        @(negedge clk);
        chk(!rdy, "R8 single pulse", rdy, 0);
        chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_drive, "R1 idle between",
            {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_drive}, 5'b10110);
        chk(rd_data == expr, "R5 hold", rd_data, expr);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 16'(i * 16'h0101) ^ 16'h5A3C;
            smem[i] = bmem[i];
        end
        exp_addr = '0; exp_data = '0; exp_mask = '0;
        we_cnt = 0; oe_cnt = 0; sel_cnt = 0; rdy_cnt = 0;
        repeat (4) @(negedge clk);
        chk(mem_ce_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_drive && !rdy, "R1 reset",
            {mem_ce_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_drive, rdy}, 6'b101100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Sweep: every write mask, then every read mask, over several addresses.
        for (int ai = 0; ai < 4; ai++) begin
            for (int wm = 0; wm < 4; wm++) begin
                do_op(1'b1, {11'(ai * 37 + 5), 8'(ai * 3 + 1)},
                      16'(16'h1111 * (ai + 1)) ^ 16'(wm * 16'h0F0F), 2'(wm));
                for (int rm = 0; rm < 4; rm++)
                    do_op(1'b0, {11'(ai * 37 + 5), 8'(ai * 3 + 1)}, 16'h0, 2'(rm));
            end
        end

        // R9: a request during a running write is ignored.
        begin
            logic [18:0] b_addr;
            logic [15:0] b_old;
            b_addr = {11'd99, 8'd200};
            b_old  = smem[200];
            @(negedge clk);
            req = 1'b1; req_wr = 1'b1; req_addr = {11'd7, 8'd50}; req_wdata = 16'hC3D2; req_mask = 2'b11;
            exp_addr = req_addr; exp_data = req_wdata; exp_mask = 2'b11;
            @(posedge clk);
            rdy_cnt = 0;
            @(negedge clk);
            req = 1'b0;
            repeat (3) @(negedge clk);
            req = 1'b1; req_wr = 1'b1; req_addr = b_addr; req_wdata = 16'hBEEF; req_mask = 2'b11;
            @(negedge clk);
            req = 1'b0;
            repeat (WAIT + 8) @(negedge clk);
            smem[50] = 16'hC3D2;
            chk(rdy_cnt == 1, "R9 one ready", rdy_cnt, 1);
            do_op(1'b0, b_addr, 16'h0, 2'b11);
            chk(rd_data == b_old, "R9 memory untouched", rd_data, b_old);
            do_op(1'b0, {11'd7, 8'd50}, 16'h0, 2'b11);
        end

        chk(v_stab == 0, "R2 R3 stable pins", v_stab, 0);
        chk(v_we == 0, "R3 we release", v_we, 0);
        chk(v_gap == 0, "R4 turnaround", v_gap, 0);
        chk(v_cont == 0, "R6 contention", v_cont, 0);
        chk(v_idle == 0, "R1 idle pins", v_idle, 0);
        chk(v_drv == 0, "R2 bus driven", v_drv, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule